// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which DMA channel the transfer engine serves next. Every channel has two ways to ask for service. One is a level request from the peripheral routed to it. The other is a software request that arrives as a single-cycle pulse and is held until that channel is served. Each channel also has an enable, a mask that blocks only the peripheral request, and a priority bit that lifts it into a high level. A global enable must be on before any channel can win.

When the engine reports idle and no grant is active, the arbiter registers a one-hot grant and the binary index of the winning channel, and raises a valid flag. Any high-priority channel beats every default-priority channel. Within one level, the lowest index wins and there is no rotation. The grant holds until the engine signals that it has finished serving that channel. The next grant can be issued at the earliest on the cycle after that.

The number of channels is set by the parameter `NUM_CH`. The default is 16, and builds with fewer channels, such as 10, are also valid.

Top module: `dma_chan_arb`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `grant_o` is all zeros, `grant_idx_o` is 0, and `grant_valid_o` and `glb_en_o` are low. All pending software requests are cleared.
- R2: No grant is issued at an edge where `glb_en_i` is low. `glb_en_o` shows the value `glb_en_i` had at the previous clock edge.
- R3: A channel whose `ch_en_i` bit is low is never granted, whether its request comes from the peripheral or from software. A software request made while the channel is disabled stays pending.
- R4: When a channel's `ch_mask_i` bit is 1, its `hw_req_i` bit is ignored, but its pending software request still qualifies it.
- R5: A 1 on bit i of `sw_req_set_i` at an edge makes channel i's software request pending from the next cycle on. The request stays pending until channel i is granted, and the same edge that issues that grant clears it. A new pulse at that same edge keeps the request pending.
- R6: Among qualified channels, any channel whose `ch_hipri_i` bit is 1 wins over every channel whose bit is 0.
- R7: Among qualified channels of the same priority level, the channel with the lowest index wins.
- R8: A grant is issued only at an edge where `eng_idle_i` is high and no grant is active. From then on, `grant_o` and `grant_idx_o` do not change until the edge at which `eng_done_i` is high. That edge clears the grant, and no new grant is issued at the same edge.
- R9: While a grant is active, `grant_o` has exactly one bit set, at position `grant_idx_o`, and `grant_valid_o` is high. Otherwise `grant_o` is zero, `grant_idx_o` is 0 and `grant_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global enable |
| ch_en_i | input | NUM_CH | Per-channel enable |
| ch_mask_i | input | NUM_CH | Per-channel mask on the peripheral request |
| ch_hipri_i | input | NUM_CH | Per-channel high-priority select |
| hw_req_i | input | NUM_CH | Peripheral request levels |
| sw_req_set_i | input | NUM_CH | Software request set pulses |
| eng_idle_i | input | 1 | Transfer engine is idle |
| eng_done_i | input | 1 | Engine finished serving the granted channel |
| grant_o | output | NUM_CH | One-hot grant |
| grant_idx_o | output | IDX_W | Index of the granted channel |
| grant_valid_o | output | 1 | A grant is active |
| glb_en_o | output | 1 | Registered status copy of the global enable |

## Verification
The assertions treat every input as synchronous to `clk_i` and settled before each rising edge. They treat `eng_done_i` as meaningful only while a grant is active, since the design ignores it at any other time. The bench changes all inputs only on the falling edge and holds them across the rising edge. It drives done pulses both while a grant is active and while none is, so the ignored case is exercised as well. The randomized phase mixes enables, masks, priorities, software pulses, idle gaps and the global enable dropping out, and a behavioural model predicts the outputs on every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

  function automatic int idx_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dma_arb_qual.sv
module dma_arb_qual #(
  parameter int NUM_CH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  input  logic [NUM_CH-1:0] hw_req_i,
  input  logic [NUM_CH-1:0] sw_req_set_i,
  input  logic [NUM_CH-1:0] sw_clr_i,
  output logic [NUM_CH-1:0] qual_o,
  output logic [NUM_CH-1:0] sw_pend_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= (pend_q & ~sw_clr_i[i]) | sw_req_set_i[i];
    end
    assign sw_pend_o[i] = pend_q;
    assign qual_o[i]    = glb_en_i & ch_en_i[i] & ((hw_req_i[i] & ~ch_mask_i[i]) | pend_q);
  end

  assert_swclr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sw_clr_i & ~sw_req_set_i)) |=> ((sw_pend_o & $past(sw_clr_i & ~sw_req_set_i)) == '0));

  assert_swset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sw_req_set_i) |=> ((sw_pend_o & $past(sw_req_set_i)) == $past(sw_req_set_i)));
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 4
) (
  input  logic [NUM_CH-1:0] qual_i,
  input  logic [NUM_CH-1:0] hipri_i,
  output logic [NUM_CH-1:0] win_oh_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic              win_any_o
);
  logic [NUM_CH-1:0] hi_req, cand;

  assign hi_req    = qual_i & hipri_i;
  assign cand      = (|hi_req) ? hi_req : qual_i;
  assign win_oh_o  = cand & (~cand + NUM_CH'(1));   // isolate lowest set bit
  assign win_any_o = |qual_i;

  always_comb begin
    win_idx_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i]) win_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
#(
  parameter  int NUM_CH = 16,
  localparam int IDX_W  = idx_width(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glb_en_i,
  input  logic [NUM_CH-1:0] ch_en_i,
  input  logic [NUM_CH-1:0] ch_mask_i,
  input  logic [NUM_CH-1:0] ch_hipri_i,
  input  logic [NUM_CH-1:0] hw_req_i,
  input  logic [NUM_CH-1:0] sw_req_set_i,
  input  logic              eng_idle_i,
  input  logic              eng_done_i,
  output logic [NUM_CH-1:0] grant_o,
  output logic [IDX_W-1:0]  grant_idx_o,
  output logic              grant_valid_o,
  output logic              glb_en_o
);
  arb_state_e        state_q;
  logic [NUM_CH-1:0] qual, sw_pend, sw_clr, win_oh;
  logic [IDX_W-1:0]  win_idx;
  logic              win_any, issue;

  assign issue  = (state_q == ARB_IDLE) & eng_idle_i & win_any;
  assign sw_clr = issue ? win_oh : '0;

  dma_arb_qual #(.NUM_CH(NUM_CH)) u_qual (
    .clk_i, .rst_ni, .glb_en_i, .ch_en_i, .ch_mask_i, .hw_req_i, .sw_req_set_i,
    .sw_clr_i (sw_clr),
    .qual_o   (qual),
    .sw_pend_o(sw_pend)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .qual_i   (qual),
    .hipri_i  (ch_hipri_i),
    .win_oh_o (win_oh),
    .win_idx_o(win_idx),
    .win_any_o(win_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ARB_IDLE;
      grant_o     <= '0;
      grant_idx_o <= '0;
      glb_en_o    <= 1'b0;
    end else begin
      glb_en_o <= glb_en_i;
      unique case (state_q)
        ARB_IDLE: if (issue) begin
          state_q     <= ARB_BUSY;
          grant_o     <= win_oh;
          grant_idx_o <= win_idx;
        end
        ARB_BUSY: if (eng_done_i) begin
          state_q     <= ARB_IDLE;
          grant_o     <= '0;
          grant_idx_o <= '0;
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign grant_valid_o = (state_q == ARB_BUSY);

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && ((|grant_o) == grant_valid_o));

  assert_idx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> grant_o[grant_idx_o]);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !eng_done_i) |=> (grant_valid_o && $stable(grant_o) && $stable(grant_idx_o)));

  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> $past(eng_idle_i));

  assert_glb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> $past(glb_en_i));

  assert_chen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> ((grant_o & ~$past(ch_en_i)) == '0));

  assert_mask_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_valid_o) |-> ((grant_o & $past(ch_mask_i & ~sw_pend)) == '0));

  assert_hipri_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(grant_valid_o) && (|$past(qual & ch_hipri_i))) |-> (|(grant_o & $past(ch_hipri_i))));
endmodule

// File: tb/dma_chan_arb_tb.sv
`timescale 1ns/1ps
module dma_chan_arb_tb;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic glb_en = 1'b0, eng_idle = 1'b0, eng_done = 1'b0;
  logic [N-1:0] ch_en = '0, ch_mask = '0, ch_hipri = '0, hw_req = '0, sw_set = '0;
  logic [N-1:0] grant;
  logic [W-1:0] grant_idx;
  logic grant_valid, glb_en_sts;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  dma_chan_arb #(.NUM_CH(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .glb_en_i(glb_en), .ch_en_i(ch_en),
    .ch_mask_i(ch_mask), .ch_hipri_i(ch_hipri), .hw_req_i(hw_req),
    .sw_req_set_i(sw_set), .eng_idle_i(eng_idle), .eng_done_i(eng_done),
    .grant_o(grant), .grant_idx_o(grant_idx), .grant_valid_o(grant_valid),
    .glb_en_o(glb_en_sts)
  );

  // behavioural reference
  bit m_busy = 0, m_glb = 0;
  bit [N-1:0] m_pend = '0;
  int m_idx = 0;
  int w;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_glb = 0; m_pend = '0; m_idx = 0;
    end else begin
      w = -1;
      if (!m_busy && eng_idle && glb_en) begin
        for (int p = 1; p >= 0; p--)
          for (int i = 0; i < N; i++)
            if (w < 0 && ch_en[i] && ch_hipri[i] == p[0] &&
                ((hw_req[i] && !ch_mask[i]) || m_pend[i])) w = i;
      end
      if (w >= 0) m_pend[w] = 1'b0;
      m_pend = m_pend | sw_set;
      if (m_busy) begin
        if (eng_done) begin m_busy = 0; m_idx = 0; end
      end else if (w >= 0) begin
        m_busy = 1; m_idx = w;
      end
      m_glb = glb_en;
    end
  end

  task automatic check();
    logic [N-1:0] e_grant;
    e_grant = m_busy ? (N'(1) << m_idx) : '0;
    total++;
    if (grant !== e_grant || grant_idx !== W'(m_idx) || grant_valid !== m_busy ||
        glb_en_sts !== m_glb) begin
      bad++;
      $display("FAIL %s: grant=%h idx=%0d valid=%b glb=%b expected grant=%h idx=%0d valid=%b glb=%b",
               cur_req, grant, grant_idx, grant_valid, glb_en_sts, e_grant, m_idx, m_busy, m_glb);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic pulse_sw(logic [N-1:0] v);
    sw_set = v; tick(); sw_set = '0;
  endtask

  task automatic finish_grant();
    eng_done = 1'b1; tick(); eng_done = 1'b0;
  endtask

  task automatic quiet();
    hw_req = '0; ch_mask = '0; ch_hipri = '0; sw_set = '0;
    finish_grant(); tick(2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    tick(3);
    rst_ni = 1'b1;
    tick(2);

    // R2 global enable gates everything
    cur_req = "R2";
    ch_en = '1; hw_req = '1; eng_idle = 1'b1;
    tick(5);
    glb_en = 1'b1;
    tick(3);                     // ch0 granted

    // R8 hold while busy, wait for idle
    cur_req = "R8";
    hw_req = 16'h0020;
    tick(4);
    finish_grant();
    eng_idle = 1'b0;
    tick(3);                     // no grant while engine busy
    eng_idle = 1'b1;
    tick(3);                     // ch5 granted
    eng_done = 1'b1; hw_req = '0; tick(2); eng_done = 1'b0; // done while idle ignored
    tick(2);

    // R3 disabled channel blocks both sources; R5 pending persists
    cur_req = "R3";
    ch_en = 16'hfffb; hw_req = 16'h0004;
    pulse_sw(16'h0004);
    tick(4);
    cur_req = "R5";
    hw_req = '0; ch_en = '1;
    tick(3);                     // ch2 granted from pending sw request
    finish_grant();
    tick(3);                     // pending cleared: no regrant

    // R4 mask ignores hw, sw still counts
    cur_req = "R4";
    ch_mask = 16'h0002; hw_req = 16'h0002;
    tick(4);
    pulse_sw(16'h0002);
    tick(3);
    quiet();

    // R5 set pulse at the grant edge keeps request pending
    cur_req = "R5";
    eng_idle = 1'b0;
    pulse_sw(16'h0100);
    eng_idle = 1'b1; sw_set = 16'h0100; tick(); sw_set = '0;
    tick(2);
    finish_grant();
    tick(3);                     // regranted ch8
    quiet();

    // R6 high priority wins
    cur_req = "R6";
    hw_req = '1; ch_hipri = 16'h1200;
    tick(3);
    finish_grant();
    tick(2);
    quiet();

    // R7 lowest index within level
    cur_req = "R7";
    hw_req = 16'h0088;
    tick(3);
    finish_grant();
    tick(3);
    quiet();

    // R9 mixed traffic
    cur_req = "R9";
    for (int k = 0; k < 4000; k++) begin
      hw_req   = N'($urandom);
      ch_en    = N'($urandom | $urandom);
      ch_mask  = N'($urandom);
      ch_hipri = N'($urandom & $urandom);
      sw_set   = N'($urandom & $urandom & $urandom);
      eng_idle = ($urandom % 4) != 0;
      eng_done = ($urandom % 3) == 0;
      glb_en   = ($urandom % 16) != 0;
      tick();
    end
    sw_set = '0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule